// File: doc/BRIEF.md
# Prescaled Match Timer with Interrupt

This block is an up-counting timer that sits on a simple word-addressed register bus. A prescaler divides the input clock by a programmable ratio, and each prescaler wrap advances a free-running main counter by one. A compare register holds a target count. When the counter steps onto that value, a sticky status flag is raised. A level interrupt is driven while the flag is set and its enable bit is on.

Software starts and stops counting with a run bit in the control register. It zeroes the counter with a clear bit and sees completion when the counter reads back zero. A third control bit freezes counting while an external debug-active input is high. Reaching the compare value never stops or reloads the counter. A driver therefore services the interrupt, adds its period to the compare register and writes a one to the status flag to clear it. Registers are selected by word index: control 0, counter 1 (read-only), interrupt enable 2, compare 3, prescale 4, status 5.

Top module: `match_tick_timer`

## Requirements
- R1: After the synchronous reset, all six registers read zero and `irq` is low.
- R2: The counter advances only while control bit 0 (run) is 1; with run at 0 it holds its value.
- R3: While control bit 1 (clear) is 1, the counter and the prescaler are held at zero whatever the run bit is. Counting restarts from zero once the bit is written back to 0.
- R4: With prescale value P, the counter increments once every P+1 clocks: P+1 clocks after the run bit is written, its value equals the number of whole periods elapsed.
- R5: The status bit (status register bit 0) is set on the clock edge at which the counter advances to a value equal to the compare register.
- R6: `irq` is the registered AND of the status bit and the interrupt enable bit (enable register bit 0). It changes one clock after either input changes.
- R7: Writing a word with bit 0 set to the status register clears the status bit. A write with bit 0 at 0 leaves it unchanged.
- R8: A compare hit neither stops nor resets the counter; it keeps incrementing at the prescaled rate.
- R9: When control bit 2 (debug halt) is 1 and `debug_active` is high, counting is frozen. With that bit at 0, `debug_active` has no effect.
- R10: If a status-clear write and a compare hit fall on the same edge, the status bit ends set.
- R11: Control, enable, compare and prescale registers read back what was written. Writes to the counter index are ignored. Read data appears on `bus_rdata` the clock after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| debug_active | input | 1 | External debug-active indication |
| irq | output | 1 | Level interrupt request |

## Verification
Each result is sampled at the clock where it is due. A register write takes effect on its own edge, and read data reflects the state before the next edge. The counter holds value n after n(P+1) edges from the run write, so the status bit rises on edge m(P+1) for compare value m and `irq` follows one edge later. The bench checks `irq` low on both edges before that, then high on the one after. The clear bit is read back zero only two edges after it is written. The same-edge conflict case is set up by counting edges so that the status-clear write lands on exactly the hit edge.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_COUNT = 1;
  localparam int unsigned IDX_MCTRL = 2;
  localparam int unsigned IDX_MATCH = 3;
  localparam int unsigned IDX_PRESC = 4;
  localparam int unsigned IDX_STAT  = 5;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT = 1;
  localparam int unsigned CTRL_DBG_BIT = 2;
  localparam int unsigned MIE_BIT      = 0;
  localparam int unsigned STAT_HIT_BIT = 0;

  typedef struct packed {
    logic dbg;
    logic clr;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/mtt_regfile.sv
module mtt_regfile
  import mtt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              stat_val,
  output ctrl_t             ctrl,
  output logic              mie,
  output logic [CNT_W-1:0]  match_val,
  output logic [PRE_W-1:0]  pre_val,
  output logic              stat_clr
);
  logic wr_en, rd_en;
  logic [DATA_W-1:0] rdata_q;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  // write-one-to-clear strobe, acts on the same edge as the write
  assign stat_clr = wr_en && (bus_addr == ADDR_W'(IDX_STAT)) && bus_wdata[STAT_HIT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      mie       <= 1'b0;
      match_val <= '0;
      pre_val   <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        ADDR_W'(IDX_CTRL): begin
          ctrl.run <= bus_wdata[CTRL_RUN_BIT];
          ctrl.clr <= bus_wdata[CTRL_CLR_BIT];
          ctrl.dbg <= bus_wdata[CTRL_DBG_BIT];
        end
        ADDR_W'(IDX_MCTRL): mie       <= bus_wdata[MIE_BIT];
        ADDR_W'(IDX_MATCH): match_val <= bus_wdata[CNT_W-1:0];
        ADDR_W'(IDX_PRESC): pre_val   <= bus_wdata[PRE_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (bus_addr)
        ADDR_W'(IDX_CTRL):  rdata_q <= DATA_W'(ctrl);
        ADDR_W'(IDX_COUNT): rdata_q <= DATA_W'(cnt_val);
        ADDR_W'(IDX_MCTRL): rdata_q <= DATA_W'(mie);
        ADDR_W'(IDX_MATCH): rdata_q <= DATA_W'(match_val);
        ADDR_W'(IDX_PRESC): rdata_q <= DATA_W'(pre_val);
        ADDR_W'(IDX_STAT):  rdata_q <= DATA_W'(stat_val);
        default:            rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/mtt_count.sv
module mtt_count #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             clr,
  input  logic             dbg_en,
  input  logic             debug_active,
  input  logic [PRE_W-1:0] pre_match,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             adv
);
  logic [PRE_W-1:0] pc_q;
  logic go, pre_wrap;

  assign go       = run_en & ~clr & ~(dbg_en & debug_active);
  // >= so that lowering the ratio mid-period wraps at once
  assign pre_wrap = (pc_q >= pre_match);
  assign adv      = go & pre_wrap;
  assign cnt_nxt  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (go) begin
      if (pre_wrap) begin
        pc_q  <= '0;
        cnt_q <= cnt_nxt;
      end else begin
        pc_q  <= pc_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/mtt_match.sv
module mtt_match #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] match_val,
  input  logic             stat_clr,
  input  logic             mie,
  output logic             stat_q,
  output logic             irq_q
);
  logic hit;

  assign hit = adv && (cnt_nxt == match_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (hit)           stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
      irq_q <= stat_q & mie;
    end
  end
endmodule

// File: rtl/match_tick_timer.sv
module match_tick_timer
  import mtt_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              debug_active,
  output logic              irq
);
  ctrl_t            ctrl;
  logic             mie, stat_clr, stat_q, adv;
  logic [CNT_W-1:0] match_val, cnt_q, cnt_nxt;
  logic [PRE_W-1:0] pre_val;

  mtt_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_val(cnt_q), .stat_val(stat_q),
    .ctrl(ctrl), .mie(mie), .match_val(match_val), .pre_val(pre_val),
    .stat_clr(stat_clr)
  );

  mtt_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
    .clk(clk), .rst(rst),
    .run_en(ctrl.run), .clr(ctrl.clr), .dbg_en(ctrl.dbg),
    .debug_active(debug_active), .pre_match(pre_val),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .adv(adv)
  );

  mtt_match #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst(rst),
    .adv(adv), .cnt_nxt(cnt_nxt), .match_val(match_val),
    .stat_clr(stat_clr), .mie(mie),
    .stat_q(stat_q), .irq_q(irq)
  );
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             clr,
  input logic             dbg,
  input logic             debug_active,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] match_val,
  input logic             stat,
  input logic             stat_clr,
  input logic             irq
);
  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt));

  // R3
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // R9
  debug_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg && debug_active && !clr) |=> $stable(cnt));

  // R5
  hit_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat) |-> (cnt == $past(match_val)));

  // R7
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat) |-> $past(stat_clr));

  // R6
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(stat));

  // R8
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((cnt != $past(cnt)) && !$past(clr)) |-> (cnt == $past(cnt) + CNT_W'(1)));
endmodule

bind match_tick_timer mtt_checker #(.CNT_W(CNT_W)) u_mtt_chk (
  .clk(clk), .rst(rst),
  .run(ctrl.run), .clr(ctrl.clr), .dbg(ctrl.dbg),
  .debug_active(debug_active),
  .cnt(cnt_q), .match_val(match_val),
  .stat(stat_q), .stat_clr(stat_clr), .irq(irq)
);

// File: tb/test_match_tick_timer.sv
module test_match_tick_timer;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int I_CTRL = 0, I_COUNT = 1, I_MCTRL = 2, I_MATCH = 3, I_PRESC = 4, I_STAT = 5;
  localparam logic [31:0] RUN = 32'h1, CLR = 32'h2, DBG = 32'h4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic debug_active = 1'b0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  match_tick_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_match_tick_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .debug_active(debug_active), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(idx); bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(idx);
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic prep(input logic [31:0] presc, input logic [31:0] m0, input logic [31:0] en);
    wr(I_CTRL, 0); wr(I_CTRL, CLR); wr(I_CTRL, 0);
    wr(I_STAT, 1); wr(I_MCTRL, en); wr(I_PRESC, presc); wr(I_MATCH, m0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    for (int i = 0; i < 6; i++) begin
      rd(i, v);
      chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(I_MATCH, 32'hA5A5_1234); rd(I_MATCH, v); chk("R11 match", v, 32'hA5A5_1234);
    wr(I_PRESC, 32'h0000_00C7); rd(I_PRESC, v); chk("R11 presc", v, 32'h0000_00C7);
    wr(I_MCTRL, 1);             rd(I_MCTRL, v); chk("R11 mctrl", v, 1);
    wr(I_CTRL, DBG);            rd(I_CTRL, v);  chk("R11 ctrl", v, DBG);
    wr(I_COUNT, 32'h55);        rd(I_COUNT, v); chk("R11 count ro", v, 0);
  endtask

  task automatic t_run_gate();
    logic [31:0] v1, v2;
    prep(0, 32'hFFFF_0000, 0);
    wr(I_CTRL, RUN);
    repeat (10) @(posedge clk);
    wr(I_CTRL, 0);
    rd(I_COUNT, v1); chk("R2 counted", 32'(v1 != 0), 1);
    repeat (10) @(posedge clk);
    rd(I_COUNT, v2); chk("R2 held", v2, v1);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    prep(0, 32'hFFFF_0000, 0);
    wr(I_CTRL, RUN);
    repeat (8) @(posedge clk);
    wr(I_CTRL, RUN | CLR);
    repeat (2) @(posedge clk);
    rd(I_COUNT, v); chk("R3 zero", v, 0);
    repeat (5) @(posedge clk);
    rd(I_COUNT, v); chk("R3 held zero", v, 0);
    wr(I_CTRL, RUN);
    repeat (4) @(posedge clk);
    rd(I_COUNT, v); chk("R3 restart", v, 4);
  endtask

  task automatic t_prescale_match();
    logic [31:0] v;
    prep(3, 5, 1);
    wr(I_CTRL, RUN);
    repeat (19) @(posedge clk);
    @(negedge clk); chk("R5 no early irq", 32'(irq), 0);
    @(posedge clk); @(negedge clk); chk("R6 irq lags flag", 32'(irq), 0);
    @(posedge clk); @(negedge clk); chk("R6 irq up", 32'(irq), 1);
    rd(I_COUNT, v); chk("R4 ratio", v, 5);
    rd(I_STAT, v);  chk("R5 flag", v, 1);
    repeat (40) @(posedge clk);
    rd(I_COUNT, v); chk("R8 free run", v, 16);
    wr(I_STAT, 0);            rd(I_STAT, v); chk("R7 zero write", v, 1);
    wr(I_STAT, 32'hFFFF_FFFE); rd(I_STAT, v); chk("R7 bit0 clear", v, 1);
    chk("R7 irq kept", 32'(irq), 1);
    wr(I_STAT, 1); rd(I_STAT, v); chk("R7 cleared", v, 0);
    chk("R7 irq drops", 32'(irq), 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    prep(0, 3, 0);
    wr(I_CTRL, RUN);
    repeat (10) @(posedge clk);
    @(negedge clk); chk("R6 masked", 32'(irq), 0);
    rd(I_STAT, v); chk("R5 flag masked", v, 1);
    wr(I_MCTRL, 1);
    @(posedge clk); @(negedge clk); chk("R6 unmask", 32'(irq), 1);
    wr(I_STAT, 1);
    @(posedge clk); @(negedge clk); chk("R7 irq clear", 32'(irq), 0);
  endtask

  task automatic t_debug();
    logic [31:0] v1, v2;
    prep(0, 32'hFFFF_0000, 0);
    debug_active = 1'b1;
    wr(I_CTRL, RUN | DBG);
    repeat (10) @(posedge clk);
    rd(I_COUNT, v1); chk("R9 frozen", v1, 0);
    debug_active = 1'b0;
    repeat (10) @(posedge clk);
    rd(I_COUNT, v1); chk("R9 resumes", 32'(v1 != 0), 1);
    wr(I_CTRL, RUN);
    debug_active = 1'b1;
    rd(I_COUNT, v1);
    repeat (5) @(posedge clk);
    rd(I_COUNT, v2); chk("R9 halt off", 32'(v2 > v1), 1);
    debug_active = 1'b0;
  endtask

  task automatic t_collide();
    logic [31:0] v;
    prep(0, 6, 0);
    wr(I_CTRL, RUN);
    repeat (5) @(posedge clk);
    wr(I_STAT, 1);
    rd(I_STAT, v); chk("R10 set wins", v, 1);
    wr(I_STAT, 1);
    rd(I_STAT, v); chk("R10 later clear", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_readback();
    t_run_gate();
    t_clear();
    t_prescale_match();
    t_mask();
    t_debug();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule